// File: doc/BRIEF.md
# Hardware cursor overlay mixer

This block sits at the end of a display pixel pipeline. Each enabled cycle it takes the scan coordinate of one pixel and that pixel's background colour, which has already gone through the palette lookup. It decides whether the pixel falls under a 64x64 hardware cursor and returns the final 24-bit colour one clock later. The cursor shape is held in a local pattern memory of 512 sixteen-bit words. Each word covers eight horizontal pixels with a 2-bit code per pixel. Code 0 lets the background through, and codes 1 to 3 pick one of three cursor colours.

The cursor origin arrives as one packed word: the column in the upper coordinate field and the row in the lower one. A single disable input removes the cursor from the whole frame. Pattern writes come in on a separate write port and do not depend on the pixel enable. The register file that drives the position, the colours and the pattern writes is outside this block, and so are the scan timing and the background lookup.

Top module: `hwc_overlay`

## Requirements
- R1: While reset is asserted and until the first enabled cycle after it, `out_rgb` is zero.
- R2: The cursor column is `cur_pos[23:12]` and the row is `cur_pos[11:0]`. A pixel is inside the cursor only when cx <= x < cx+64 and cy <= y < cy+64. Every other pixel outputs its background colour.
- R3: Inside the cursor, the pattern word used is the one written at address (y-cy)*8 + (x-cx)/8.
- R4: Within that word, the pixel's 2-bit code is taken from bits [2k+1:2k], where k = (x-cx) mod 8.
- R5: Code 0 outputs the background colour. Code c in 1..3 outputs cursor colour c, which is `cur_pal[24*(c-1) +: 24]`.
- R6: While `cur_off` is 1, every pixel outputs its background colour.
- R7: The colour for a pixel presented in an enabled cycle appears on `out_rgb` after the next rising clock edge and not before it.
- R8: While `pix_en` is 0, `out_rgb` keeps its value. A pattern write still takes effect and is seen by later enabled pixels.
- R9: The window test is signed. A cursor whose origin is near the coordinate maximum covers no pixel at small coordinates, so there is no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel clock enable; the inputs below are sampled when it is 1 |
| scan_x | input | 12 | Column of the current pixel |
| scan_y | input | 12 | Row of the current pixel |
| bg_rgb | input | 24 | Background colour of the current pixel |
| cur_pos | input | 24 | Cursor origin: column in [23:12], row in [11:0] |
| cur_off | input | 1 | 1 hides the cursor |
| cur_pal | input | 72 | Three cursor colours, colour 1 in the lowest 24 bits |
| pat_we | input | 1 | Pattern memory write strobe |
| pat_waddr | input | 9 | Pattern word address |
| pat_wdata | input | 16 | Pattern word, eight 2-bit codes |
| out_rgb | output | 24 | Mixed colour, one cycle after the pixel |

## Verification
The assertions assume that `cur_pal` stays constant over the cycles they compare, because the output mux reads the colours directly. They also assume that no enabled pixel is presented during the two cycles after `rst_n` rises, while the internal reset synchroniser is still releasing. The bench drives the colours once before any pixel and changes them only while the block is idle. It waits several cycles after reset before it raises `pix_en`. All pattern writes finish before the sweeps read the memory, so no read and write ever hit the same word in the same cycle.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int unsigned HWC_COORD_W = 12;
  localparam int unsigned HWC_DIM     = 64;
  localparam int unsigned HWC_PPW     = 8;
  localparam int unsigned HWC_OP_W    = 2;
  localparam int unsigned HWC_RGB_W   = 24;
endpackage

// File: rtl/hwc_window.sv
module hwc_window #(
  parameter int unsigned COORD_W = hwc_pkg::HWC_COORD_W,
  parameter int unsigned DIM     = hwc_pkg::HWC_DIM,
  parameter int unsigned PPW     = hwc_pkg::HWC_PPW,
  localparam int unsigned DIM_W  = $clog2(DIM),
  localparam int unsigned SUB_W  = $clog2(PPW),
  localparam int unsigned IDX_W  = $clog2(DIM * DIM / PPW)
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] cx,
  input  logic [COORD_W-1:0] cy,
  input  logic               off,
  output logic               hit,
  output logic [IDX_W-1:0]   word_idx,
  output logic [SUB_W-1:0]   sub
);
  // one extra bit keeps the difference signed
  logic signed [COORD_W:0] dx, dy;
  logic                    in_x, in_y;

  always_comb begin
    dx = $signed({1'b0, x}) - $signed({1'b0, cx});
    dy = $signed({1'b0, y}) - $signed({1'b0, cy});
    // in range [0, DIM) when all bits above the offset field are clear
    in_x = (dx[COORD_W:DIM_W] == '0);
    in_y = (dy[COORD_W:DIM_W] == '0);
    hit      = in_x && in_y && !off;
    word_idx = {dy[DIM_W-1:0], dx[DIM_W-1:SUB_W]};
    sub      = dx[SUB_W-1:0];
  end
endmodule

// File: rtl/hwc_patmem.sv
module hwc_patmem #(
  parameter int unsigned WORDS  = 512,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/hwc_colsel.sv
module hwc_colsel #(
  parameter int unsigned RGB_W = hwc_pkg::HWC_RGB_W,
  parameter int unsigned OP_W  = hwc_pkg::HWC_OP_W,
  parameter int unsigned PPW   = hwc_pkg::HWC_PPW,
  localparam int unsigned NPAL  = (1 << OP_W) - 1,
  localparam int unsigned SUB_W = $clog2(PPW),
  localparam int unsigned WORD_W = PPW * OP_W
) (
  input  logic                  hit,
  input  logic [WORD_W-1:0]     word,
  input  logic [SUB_W-1:0]      sub,
  input  logic [RGB_W-1:0]      bg,
  input  logic [NPAL*RGB_W-1:0] pal_flat,
  output logic [RGB_W-1:0]      rgb
);
  // entry 0 is the transparent code and maps to the background
  logic [RGB_W-1:0] choice [NPAL+1];
  logic [OP_W-1:0]  op;

  assign choice[0] = bg;
  for (genvar k = 1; k <= NPAL; k++) begin : g_pal
    assign choice[k] = pal_flat[(k-1)*RGB_W +: RGB_W];
  end

  always_comb begin
    op  = word[sub*OP_W +: OP_W];
    rgb = hit ? choice[op] : bg;
  end
endmodule

// File: rtl/hwc_overlay.sv
module hwc_overlay #(
  parameter int unsigned COORD_W = hwc_pkg::HWC_COORD_W,
  parameter int unsigned DIM     = hwc_pkg::HWC_DIM,
  parameter int unsigned PPW     = hwc_pkg::HWC_PPW,
  parameter int unsigned OP_W    = hwc_pkg::HWC_OP_W,
  parameter int unsigned RGB_W   = hwc_pkg::HWC_RGB_W,
  localparam int unsigned NPAL   = (1 << OP_W) - 1,
  localparam int unsigned WORDS  = DIM * DIM / PPW,
  localparam int unsigned IDX_W  = $clog2(WORDS),
  localparam int unsigned SUB_W  = $clog2(PPW),
  localparam int unsigned WORD_W = PPW * OP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_en,
  input  logic [COORD_W-1:0]    scan_x,
  input  logic [COORD_W-1:0]    scan_y,
  input  logic [RGB_W-1:0]      bg_rgb,
  input  logic [2*COORD_W-1:0]  cur_pos,
  input  logic                  cur_off,
  input  logic [NPAL*RGB_W-1:0] cur_pal,
  input  logic                  pat_we,
  input  logic [IDX_W-1:0]      pat_waddr,
  input  logic [WORD_W-1:0]     pat_wdata,
  output logic [RGB_W-1:0]      out_rgb
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              win_hit;
  logic [IDX_W-1:0]  win_idx;
  logic [SUB_W-1:0]  win_sub;
  logic [WORD_W-1:0] pat_q;
  logic              hit_q, hit_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [RGB_W-1:0]  bg_q,  bg_d;

  // reset asserts at once and releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  hwc_window #(.COORD_W(COORD_W), .DIM(DIM), .PPW(PPW)) u_window (
    .x        (scan_x),
    .y        (scan_y),
    .cx       (cur_pos[2*COORD_W-1:COORD_W]),
    .cy       (cur_pos[COORD_W-1:0]),
    .off      (cur_off),
    .hit      (win_hit),
    .word_idx (win_idx),
    .sub      (win_sub)
  );

  hwc_patmem #(.WORDS(WORDS), .WORD_W(WORD_W)) u_patmem (
    .clk   (clk),
    .we    (pat_we),
    .waddr (pat_waddr),
    .wdata (pat_wdata),
    .re    (pix_en),
    .raddr (win_idx),
    .rdata (pat_q)
  );

  // next state: the side signals travel with the memory read
  always_comb begin
    hit_d = hit_q;
    sub_d = sub_q;
    bg_d  = bg_q;
    if (pix_en) begin
      hit_d = win_hit;
      sub_d = win_sub;
      bg_d  = bg_rgb;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hit_q <= 1'b0;
      sub_q <= '0;
      bg_q  <= '0;
    end else begin
      hit_q <= hit_d;
      sub_q <= sub_d;
      bg_q  <= bg_d;
    end
  end

  hwc_colsel #(.RGB_W(RGB_W), .OP_W(OP_W), .PPW(PPW)) u_colsel (
    .hit      (hit_q),
    .word     (pat_q),
    .sub      (sub_q),
    .bg       (bg_q),
    .pal_flat (cur_pal),
    .rgb      (out_rgb)
  );
endmodule

// File: rtl/hwc_overlay_chk.sv
module hwc_overlay_chk #(
  parameter int unsigned COORD_W = 12,
  parameter int unsigned DIM     = 64,
  parameter int unsigned RGB_W   = 24,
  parameter int unsigned NPAL    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pix_en,
  input logic [COORD_W-1:0]    scan_x,
  input logic [COORD_W-1:0]    scan_y,
  input logic [RGB_W-1:0]      bg_rgb,
  input logic [2*COORD_W-1:0]  cur_pos,
  input logic                  cur_off,
  input logic [NPAL*RGB_W-1:0] cur_pal,
  input logic [RGB_W-1:0]      out_rgb
);
  logic [COORD_W:0] off_x, off_y;
  logic             covered;
  logic             is_pal;

  always_comb begin
    off_x   = {1'b0, scan_x} - {1'b0, cur_pos[2*COORD_W-1:COORD_W]};
    off_y   = {1'b0, scan_y} - {1'b0, cur_pos[COORD_W-1:0]};
    covered = (off_x < (COORD_W+1)'(DIM)) && (off_y < (COORD_W+1)'(DIM));
    is_pal  = 1'b0;
    for (int k = 0; k < int'(NPAL); k++) begin
      if (out_rgb == cur_pal[k*RGB_W +: RGB_W]) is_pal = 1'b1;
    end
  end

  AST_OFF_SHOWS_BG: assert property (@(posedge clk) disable iff (!rst_n) (pix_en && cur_off) |=> (out_rgb == $past(bg_rgb))); // R6
  AST_OUTSIDE_SHOWS_BG: assert property (@(posedge clk) disable iff (!rst_n) (pix_en && !covered) |=> (out_rgb == $past(bg_rgb))); // R2
  AST_OUT_FROM_SET: assert property (@(posedge clk) disable iff (!rst_n) pix_en |=> (is_pal || out_rgb == $past(bg_rgb))); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !pix_en |=> $stable(out_rgb)); // R8
endmodule

bind hwc_overlay hwc_overlay_chk #(
  .COORD_W(COORD_W), .DIM(DIM), .RGB_W(RGB_W), .NPAL(NPAL)
) i_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .scan_x(scan_x), .scan_y(scan_y),
  .bg_rgb(bg_rgb), .cur_pos(cur_pos), .cur_off(cur_off), .cur_pal(cur_pal),
  .out_rgb(out_rgb)
);

// File: tb/test_hwc_overlay.sv
`timescale 1ns/1ps
module test_hwc_overlay;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en;
  logic [11:0] scan_x, scan_y;
  logic [23:0] bg_rgb;
  logic [23:0] cur_pos;
  logic        cur_off;
  logic [71:0] cur_pal;
  logic        pat_we;
  logic [8:0]  pat_waddr;
  logic [15:0] pat_wdata;
  logic [23:0] out_rgb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cx_m, cy_m;
  bit off_m;

  always #4 clk = ~clk;

  hwc_overlay i_hwc_overlay (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .scan_x(scan_x), .scan_y(scan_y),
    .bg_rgb(bg_rgb), .cur_pos(cur_pos), .cur_off(cur_off), .cur_pal(cur_pal),
    .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wdata(pat_wdata), .out_rgb(out_rgb)
  );

  localparam logic [23:0] PAL1 = 24'hFF0000;
  localparam logic [23:0] PAL2 = 24'h00FF00;
  localparam logic [23:0] PAL3 = 24'h0000FF;

  function automatic logic [15:0] pat_word(int i);
    return 16'((i * 40503) ^ (i << 7) ^ 32'h1234);
  endfunction

  function automatic logic [23:0] bg_of(int x, int y);
    return {8'(x), 8'(y), 8'h5A};
  endfunction

  function automatic logic [23:0] expect_rgb(int x, int y, output string tag);
    int dx, dy, op;
    dx = x - cx_m;
    dy = y - cy_m;
    if (off_m) begin
      tag = "R6";
      return bg_of(x, y);
    end
    if (dx < 0 || dx >= 64 || dy < 0 || dy >= 64) begin
      tag = "R2/R9";
      return bg_of(x, y);
    end
    op = int'(pat_word(dy * 8 + dx / 8) >> ((dx % 8) * 2)) & 3;
    tag = (op == 0) ? "R5" : "R3/R4/R5";
    case (op)
      1: return PAL1;
      2: return PAL2;
      3: return PAL3;
      default: return bg_of(x, y);
    endcase
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_pix(int x, int y);
    scan_x = 12'(x);
    scan_y = 12'(y);
    bg_rgb = bg_of(x, y);
    pix_en = 1'b1;
  endtask

  task automatic set_cursor(int cx, int cy, bit off);
    @(negedge clk);
    pix_en  = 1'b0;
    cur_pos = {12'(cx), 12'(cy)};
    cur_off = off;
    cx_m = cx; cy_m = cy; off_m = off;
  endtask

  task automatic sweep(int x0, int x1, int y0, int y1);
    string tag;
    logic [23:0] e;
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) begin
        @(negedge clk);
        drive_pix(x, y);
        e = expect_rgb(x, y, tag);
        @(posedge clk);
        #1;
        check(tag, out_rgb, e);
      end
    end
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  initial begin
    string tag;
    logic [23:0] e1, e2, held;
    rst_n = 1'b0; pix_en = 1'b0; scan_x = '0; scan_y = '0; bg_rgb = '0;
    cur_pos = '0; cur_off = 1'b0; cur_pal = {PAL3, PAL2, PAL1};
    pat_we = 1'b0; pat_waddr = '0; pat_wdata = '0;
    cx_m = 0; cy_m = 0; off_m = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", out_rgb, 24'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check("R1 after reset", out_rgb, 24'h0);

    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      pat_we = 1'b1;
      pat_waddr = 9'(i);
      pat_wdata = pat_word(i);
    end
    @(negedge clk);
    pat_we = 1'b0;

    // interior position
    set_cursor(100, 50, 1'b0);
    sweep(90, 170, 45, 120);
    // origin at zero
    set_cursor(0, 0, 1'b0);
    sweep(0, 70, 0, 70);
    // R9: origin near the maximum, no wrap to small coordinates
    set_cursor(4090, 4090, 1'b0);
    sweep(0, 8, 0, 8);
    sweep(4080, 4095, 4080, 4095);
    sweep(0, 8, 4085, 4095);
    // R6: disabled cursor
    set_cursor(100, 50, 1'b1);
    sweep(95, 170, 48, 60);

    // R7: one-cycle latency
    set_cursor(100, 50, 1'b0);
    @(negedge clk);
    drive_pix(100, 50);
    e1 = expect_rgb(100, 50, tag);
    @(posedge clk);
    #1;
    check("R7 first pixel", out_rgb, e1);
    @(negedge clk);
    drive_pix(20, 20);
    e2 = expect_rgb(20, 20, tag);
    #1;
    check("R7 before edge", out_rgb, e1);
    @(posedge clk);
    #1;
    check("R7 after edge", out_rgb, e2);

    // R8: idle holds, pattern write during idle still lands
    @(negedge clk);
    pix_en = 1'b0;
    held = out_rgb;
    scan_x = 12'd101; scan_y = 12'd51; bg_rgb = 24'h123456;
    pat_we = 1'b1; pat_waddr = 9'd8; pat_wdata = 16'hFFFF;
    @(posedge clk);
    #1;
    check("R8 hold during write", out_rgb, held);
    @(negedge clk);
    pat_we = 1'b0;
    @(posedge clk);
    #1;
    check("R8 hold idle", out_rgb, held);
    @(negedge clk);
    drive_pix(101, 51);
    @(posedge clk);
    #1;
    check("R8 written word used", out_rgb, PAL3);
    @(negedge clk);
    pix_en = 1'b0;

    // R1: reset asserted mid-run clears output
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", out_rgb, 24'h0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule